// File: doc/BRIEF.md
# Software-Pipelined Loop Branch Resolver

This block settles the outcome of loop-closing branches in a predicated machine with rotating registers. Each cycle it may receive one branch request. A request carries an opcode, the bundle slot the branch occupies and the value of its qualifying predicate. The block holds four pieces of loop state: a 64-bit iteration counter, a 6-bit drain counter, a 7-bit rotation base and the loop-control predicate bit. One cycle after a request it reports three things: whether the branch is taken, whether it is illegal, and the updated state together with a write-enable for each state field.

There are two families of loop branch. The counted branch steps the iteration counter down. The two while-style branches (top and exit) use the qualifying predicate and the drain counter to tell which stage the pipelined loop is in: steady state, filling or draining, last drain step, or fully drained. From that stage they set the taken decision and update the rotation state. The exit form always gives the opposite branch sense to the top form. An initialisation port loads all state while reset is held, and also on any cycle where its write strobe is high.

Top module: `loopbr_resolver`

## Requirements
- R1: While rst_n is low, and in any cycle with init_we high, every state output takes the init_* values on the next rising edge and rsp_valid is 0. A request in the same cycle as init_we is dropped.
- R2: A loop opcode (req_op 1, 2 or 3) whose req_slot is not 2 gives rsp_fault=1 and rsp_taken=0, raises no write-enable and changes no state, for any predicate value.
- R3: req_op 0 (not a loop branch) gives rsp_valid=1 with rsp_fault=0, rsp_taken=0, no write-enable and no state change, in any slot.
- R4: A counted branch (req_op 1) in slot 2 with a nonzero iteration count is taken and decrements the count.
- R5: A counted branch with an iteration count of 0 falls through and leaves the count at 0.
- R6: A while branch (req_op 2 = top, 3 = exit) with the predicate true keeps the drain count, clears the control bit and decrements the rotation base. Top is taken and exit falls through.
- R7: With the predicate false and a drain count above 1, the drain count and the rotation base both decrement and the control bit clears. Top is taken and exit falls through.
- R8: With the predicate false and a drain count of exactly 1, the drain count goes to 0, the base decrements and the control bit clears. Top falls through and exit is taken.
- R9: With the predicate false and a drain count of 0, the drain count and the base are kept and the control bit clears. Top falls through and exit is taken.
- R10: Decrementing a rotation base of 0 gives 95 (wrap modulo 96).
- R11: A legal counted branch raises lc_we alone. A legal while branch raises ec_we, rrb_we and p63_we together. Both hold whether the branch is taken or not.
- R12: rsp_valid is high exactly one cycle after req_valid is sampled high with init_we low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; while low, state loads from init_* |
| req_valid | input | 1 | Branch request present |
| req_op | input | 2 | 0 none, 1 counted, 2 while-top, 3 while-exit |
| req_slot | input | 2 | Bundle slot of the branch |
| req_qp | input | 1 | Qualifying predicate value |
| init_we | input | 1 | Load state from init_* |
| init_lc | input | 64 | Initial iteration count |
| init_ec | input | 6 | Initial drain count |
| init_rrb | input | 7 | Initial rotation base |
| init_p63 | input | 1 | Initial control predicate |
| rsp_valid | output | 1 | Response present |
| rsp_taken | output | 1 | Branch taken |
| rsp_fault | output | 1 | Illegal-operation fault |
| lc_q | output | 64 | Iteration count |
| ec_q | output | 6 | Drain count |
| rrb_q | output | 7 | Rotation base |
| p63_q | output | 1 | Control predicate |
| lc_we | output | 1 | Iteration count written |
| ec_we | output | 1 | Drain count written |
| rrb_we | output | 1 | Rotation base written |
| p63_we | output | 1 | Control predicate written |

## Verification
The bound assertions check these properties on every cycle: the response arrives one cycle after the request; a misplaced loop branch faults with no writes; the fault and taken flags are never high together; the two write-enable groups never overlap; a while write always leaves the control bit clear; and neither counter ever increases when written. Only the bench scenarios can show the exact taken sense of each of the four pipeline stages for top and for exit. The same holds for the precise decrement values, the wrap of the rotation base from 0 to 95, the counted branch at a count of zero and at its largest value, and the dropping of a request that arrives together with an initialisation write.

// File: rtl/loopbr_pkg.sv
package loopbr_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CLOOP = 2'd1,
    OP_WTOP  = 2'd2,
    OP_WEXIT = 2'd3
  } loop_op_e;

  typedef enum logic [1:0] {
    STG_KERNEL  = 2'd0,
    STG_FILLDRN = 2'd1,
    STG_LASTDRN = 2'd2,
    STG_DRAINED = 2'd3
  } loop_stage_e;
endpackage

// File: rtl/loopbr_slot_check.sv
module loopbr_slot_check import loopbr_pkg::*; #(
  parameter int SLOT_W    = 2,
  parameter int LOOP_SLOT = 2
) (
  input  logic [1:0]        op_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              is_loop_o,
  output logic              fault_o
);
  assign is_loop_o = (op_i != OP_NONE);
  // placement fault does not depend on the branch outcome
  assign fault_o   = is_loop_o && (slot_i != SLOT_W'(LOOP_SLOT));
endmodule

// File: rtl/loopbr_count_unit.sv
module loopbr_count_unit #(
  parameter int LC_W = 64
) (
  input  logic [LC_W-1:0] lc_i,
  output logic            taken_o,
  output logic [LC_W-1:0] lc_next_o
);
  function automatic logic [LC_W-1:0] lc_step(input logic [LC_W-1:0] v);
    return (v == '0) ? v : v - LC_W'(1);
  endfunction

  assign taken_o   = (lc_i != '0);
  assign lc_next_o = lc_step(lc_i);
endmodule

// File: rtl/loopbr_while_unit.sv
module loopbr_while_unit import loopbr_pkg::*; #(
  parameter int EC_W    = 6,
  parameter int RRB_W   = 7,
  parameter int RRB_MOD = 96
) (
  input  logic             exit_i,
  input  logic             qp_i,
  input  logic [EC_W-1:0]  ec_i,
  input  logic [RRB_W-1:0] rrb_i,
  output loop_stage_e      stage_o,
  output logic             taken_o,
  output logic [EC_W-1:0]  ec_next_o,
  output logic [RRB_W-1:0] rrb_next_o
);
  localparam logic [RRB_W-1:0] RRB_TOP = RRB_W'(RRB_MOD - 1);

  function automatic logic [RRB_W-1:0] rrb_dec(input logic [RRB_W-1:0] r);
    return (r == '0) ? RRB_TOP : r - RRB_W'(1);
  endfunction

  logic top_take;
  logic rot;

  always_comb begin
    if (qp_i)                     stage_o = STG_KERNEL;
    else if (ec_i > EC_W'(1))     stage_o = STG_FILLDRN;
    else if (ec_i == EC_W'(1))    stage_o = STG_LASTDRN;
    else                          stage_o = STG_DRAINED;
  end

  always_comb begin
    top_take  = 1'b0;
    rot       = 1'b1;
    ec_next_o = ec_i;
    unique case (stage_o)
      STG_KERNEL:  top_take = 1'b1;
      STG_FILLDRN: begin top_take = 1'b1; ec_next_o = ec_i - EC_W'(1); end
      STG_LASTDRN: ec_next_o = ec_i - EC_W'(1);
      STG_DRAINED: rot = 1'b0;
      default:     rot = 1'b0;
    endcase
  end

  assign taken_o    = exit_i ? ~top_take : top_take;
  assign rrb_next_o = rot ? rrb_dec(rrb_i) : rrb_i;
endmodule

// File: rtl/loopbr_resolver.sv
module loopbr_resolver import loopbr_pkg::*; #(
  parameter int LC_W      = 64,
  parameter int EC_W      = 6,
  parameter int RRB_W     = 7,
  parameter int RRB_MOD   = 96,
  parameter int SLOT_W    = 2,
  parameter int LOOP_SLOT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic              req_qp,
  input  logic              init_we,
  input  logic [LC_W-1:0]   init_lc,
  input  logic [EC_W-1:0]   init_ec,
  input  logic [RRB_W-1:0]  init_rrb,
  input  logic              init_p63,
  output logic              rsp_valid,
  output logic              rsp_taken,
  output logic              rsp_fault,
  output logic [LC_W-1:0]   lc_q,
  output logic [EC_W-1:0]   ec_q,
  output logic [RRB_W-1:0]  rrb_q,
  output logic              p63_q,
  output logic              lc_we,
  output logic              ec_we,
  output logic              rrb_we,
  output logic              p63_we
);
  // named internal events
  logic              req_fire;
  logic              is_loop;
  logic              slot_fault;
  logic              do_cloop;
  logic              do_while;
  logic              cnt_taken;
  logic [LC_W-1:0]   cnt_lc_next;
  loop_stage_e       wh_stage;
  logic              wh_taken;
  logic [EC_W-1:0]   wh_ec_next;
  logic [RRB_W-1:0]  wh_rrb_next;
  logic              next_taken;

  assign req_fire = req_valid && !init_we;

  loopbr_slot_check #(.SLOT_W(SLOT_W), .LOOP_SLOT(LOOP_SLOT)) u_slot (
    .op_i(req_op), .slot_i(req_slot), .is_loop_o(is_loop), .fault_o(slot_fault)
  );

  loopbr_count_unit #(.LC_W(LC_W)) u_cnt (
    .lc_i(lc_q), .taken_o(cnt_taken), .lc_next_o(cnt_lc_next)
  );

  loopbr_while_unit #(.EC_W(EC_W), .RRB_W(RRB_W), .RRB_MOD(RRB_MOD)) u_wh (
    .exit_i(req_op == OP_WEXIT), .qp_i(req_qp), .ec_i(ec_q), .rrb_i(rrb_q),
    .stage_o(wh_stage), .taken_o(wh_taken), .ec_next_o(wh_ec_next),
    .rrb_next_o(wh_rrb_next)
  );

  assign do_cloop = req_fire && is_loop && !slot_fault && (req_op == OP_CLOOP);
  assign do_while = req_fire && is_loop && !slot_fault &&
                    ((req_op == OP_WTOP) || (req_op == OP_WEXIT));
  assign next_taken = (do_cloop && cnt_taken) || (do_while && wh_taken);

  always_ff @(posedge clk) begin
    if (!rst_n || init_we) begin
      lc_q      <= init_lc;
      ec_q      <= init_ec;
      rrb_q     <= init_rrb;
      p63_q     <= init_p63;
      rsp_valid <= 1'b0;
      rsp_taken <= 1'b0;
      rsp_fault <= 1'b0;
      lc_we     <= 1'b0;
      ec_we     <= 1'b0;
      rrb_we    <= 1'b0;
      p63_we    <= 1'b0;
    end else begin
      rsp_valid <= req_fire;
      rsp_taken <= next_taken;
      rsp_fault <= req_fire && slot_fault;
      lc_we     <= do_cloop;
      ec_we     <= do_while;
      rrb_we    <= do_while;
      p63_we    <= do_while;
      if (do_cloop) lc_q <= cnt_lc_next;
      if (do_while) begin
        ec_q  <= wh_ec_next;
        rrb_q <= wh_rrb_next;
        p63_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/loopbr_resolver_chk.sv
module loopbr_resolver_chk #(
  parameter int LC_W      = 64,
  parameter int EC_W      = 6,
  parameter int RRB_W     = 7,
  parameter int SLOT_W    = 2,
  parameter int LOOP_SLOT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              init_we,
  input logic [1:0]        req_op,
  input logic [SLOT_W-1:0] req_slot,
  input logic              rsp_valid,
  input logic              rsp_taken,
  input logic              rsp_fault,
  input logic [LC_W-1:0]   lc_q,
  input logic [EC_W-1:0]   ec_q,
  input logic [RRB_W-1:0]  rrb_q,
  input logic              p63_q,
  input logic              lc_we,
  input logic              ec_we,
  input logic              rrb_we,
  input logic              p63_we
);
  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !init_we) |=> rsp_valid);

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || init_we) |=> !rsp_valid);

  p_slot_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !init_we && req_op != 2'd0 && req_slot != SLOT_W'(LOOP_SLOT))
    |=> (rsp_fault && !rsp_taken && !lc_we && !ec_we && !rrb_we && !p63_we));

  p_fault_not_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> !rsp_taken);

  p_we_groups_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(lc_we && ec_we) && (ec_we == rrb_we) && (ec_we == p63_we));

  p_p63_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    p63_we |-> !p63_q);

  p_ec_nonincr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ec_we |-> (ec_q <= $past(ec_q)));

  p_lc_nonincr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lc_we |-> (lc_q <= $past(lc_q)));
endmodule

bind loopbr_resolver loopbr_resolver_chk #(
  .LC_W(LC_W), .EC_W(EC_W), .RRB_W(RRB_W), .SLOT_W(SLOT_W), .LOOP_SLOT(LOOP_SLOT)
) u_chk (.*);

// File: tb/loopbr_resolver_bench.sv
`timescale 1ns/1ps
module loopbr_resolver_bench;
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  slot;
    logic        qp;
    logic [63:0] lc;
    logic [5:0]  ec;
    logic [6:0]  rrb;
    logic        p63;
    logic        tk;
    logic        flt;
    logic [63:0] elc;
    logic [5:0]  eec;
    logic [6:0]  err;
    logic        ep63;
    logic [3:0]  ewe;   // {lc, ec, rrb, p63}
    logic [7:0]  rq;    // requirement number for messages
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R4 counted nonzero
    '{2'd1,2'd2,1'b0,64'd5,6'd3,7'd10,1'b1, 1'b1,1'b0,64'd4,6'd3,7'd10,1'b1,4'b1000,8'd4},
    // R5 counted zero
    '{2'd1,2'd2,1'b0,64'd0,6'd3,7'd10,1'b1, 1'b0,1'b0,64'd0,6'd3,7'd10,1'b1,4'b1000,8'd5},
    // R2 counted in slot 0
    '{2'd1,2'd0,1'b0,64'd5,6'd3,7'd10,1'b1, 1'b0,1'b1,64'd5,6'd3,7'd10,1'b1,4'b0000,8'd2},
    // R6 kernel top / exit
    '{2'd2,2'd2,1'b1,64'd5,6'd3,7'd10,1'b1, 1'b1,1'b0,64'd5,6'd3,7'd9,1'b0,4'b0111,8'd6},
    '{2'd3,2'd2,1'b1,64'd5,6'd3,7'd10,1'b1, 1'b0,1'b0,64'd5,6'd3,7'd9,1'b0,4'b0111,8'd6},
    // R7 drain count above 1
    '{2'd2,2'd2,1'b0,64'd5,6'd3,7'd10,1'b1, 1'b1,1'b0,64'd5,6'd2,7'd9,1'b0,4'b0111,8'd7},
    '{2'd3,2'd2,1'b0,64'd5,6'd3,7'd10,1'b1, 1'b0,1'b0,64'd5,6'd2,7'd9,1'b0,4'b0111,8'd7},
    // R8 drain count 1
    '{2'd2,2'd2,1'b0,64'd5,6'd1,7'd10,1'b1, 1'b0,1'b0,64'd5,6'd0,7'd9,1'b0,4'b0111,8'd8},
    '{2'd3,2'd2,1'b0,64'd5,6'd1,7'd10,1'b1, 1'b1,1'b0,64'd5,6'd0,7'd9,1'b0,4'b0111,8'd8},
    // R9 drained
    '{2'd2,2'd2,1'b0,64'd5,6'd0,7'd10,1'b1, 1'b0,1'b0,64'd5,6'd0,7'd10,1'b0,4'b0111,8'd9},
    '{2'd3,2'd2,1'b0,64'd5,6'd0,7'd10,1'b1, 1'b1,1'b0,64'd5,6'd0,7'd10,1'b0,4'b0111,8'd9},
    // R10 wrap
    '{2'd2,2'd2,1'b1,64'd5,6'd4,7'd0,1'b1,  1'b1,1'b0,64'd5,6'd4,7'd95,1'b0,4'b0111,8'd10},
    '{2'd3,2'd2,1'b0,64'd5,6'd2,7'd0,1'b0,  1'b0,1'b0,64'd5,6'd1,7'd95,1'b0,4'b0111,8'd10},
    // R2 while-top in slot 1
    '{2'd2,2'd1,1'b1,64'd5,6'd3,7'd10,1'b1, 1'b0,1'b1,64'd5,6'd3,7'd10,1'b1,4'b0000,8'd2},
    // R3 non-loop opcode
    '{2'd0,2'd0,1'b1,64'd5,6'd3,7'd10,1'b1, 1'b0,1'b0,64'd5,6'd3,7'd10,1'b1,4'b0000,8'd3},
    // R4 largest count
    '{2'd1,2'd2,1'b1,64'hFFFF_FFFF_FFFF_FFFF,6'd3,7'd10,1'b1, 1'b1,1'b0,64'hFFFF_FFFF_FFFF_FFFE,6'd3,7'd10,1'b1,4'b1000,8'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [1:0] req_slot = 2'd0;
  logic req_qp = 1'b0;
  logic init_we = 1'b0;
  logic [63:0] init_lc = 64'd0;
  logic [5:0] init_ec = 6'd0;
  logic [6:0] init_rrb = 7'd0;
  logic init_p63 = 1'b0;
  logic rsp_valid, rsp_taken, rsp_fault;
  logic [63:0] lc_q;
  logic [5:0] ec_q;
  logic [6:0] rrb_q;
  logic p63_q, lc_we, ec_we, rrb_we, p63_we;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  loopbr_resolver u_loopbr_resolver (
    .clk, .rst_n, .req_valid, .req_op, .req_slot, .req_qp, .init_we,
    .init_lc, .init_ec, .init_rrb, .init_p63, .rsp_valid, .rsp_taken, .rsp_fault,
    .lc_q, .ec_q, .rrb_q, .p63_q, .lc_we, .ec_we, .rrb_we, .p63_we
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic load(input logic [63:0] lc, input logic [5:0] ec, input logic [6:0] rrb, input logic p);
    @(negedge clk);
    init_we = 1'b1; init_lc = lc; init_ec = ec; init_rrb = rrb; init_p63 = p;
    @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] slot, input logic qp);
    req_valid = 1'b1; req_op = op; req_slot = slot; req_qp = qp;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input int i);
    string t;
    load(VECS[i].lc, VECS[i].ec, VECS[i].rrb, VECS[i].p63);
    issue(VECS[i].op, VECS[i].slot, VECS[i].qp);
    t = $sformatf("R%0d vec%0d", VECS[i].rq, i);
    chk({t, " valid"}, 64'(rsp_valid), 64'd1);
    chk({t, " taken"}, 64'(rsp_taken), 64'(VECS[i].tk));
    chk({t, " fault"}, 64'(rsp_fault), 64'(VECS[i].flt));
    chk({t, " lc"},    lc_q, VECS[i].elc);
    chk({t, " ec"},    64'(ec_q), 64'(VECS[i].eec));
    chk({t, " rrb"},   64'(rrb_q), 64'(VECS[i].err));
    chk({t, " p63"},   64'(p63_q), 64'(VECS[i].ep63));
    chk({t, " we (R11)"}, 64'({lc_we, ec_we, rrb_we, p63_we}), 64'(VECS[i].ewe));
  endtask

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    // R1: state follows init port during reset
    init_lc = 64'd77; init_ec = 6'd9; init_rrb = 7'd42; init_p63 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset lc", lc_q, 64'd77);
    chk("R1 reset ec", 64'(ec_q), 64'd9);
    chk("R1 reset rrb", 64'(rrb_q), 64'd42);
    chk("R1 reset p63", 64'(p63_q), 64'd1);
    chk("R1 reset valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: no response without a request
    chk("R12 idle valid", 64'(rsp_valid), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R1: request together with init write is dropped
    load(64'd3, 6'd3, 7'd3, 1'b1);
    req_valid = 1'b1; req_op = 2'd2; req_slot = 2'd2; req_qp = 1'b1;
    init_we = 1'b1; init_lc = 64'd8; init_ec = 6'd8; init_rrb = 7'd8; init_p63 = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; init_we = 1'b0;
    chk("R1 init wins valid", 64'(rsp_valid), 64'd0);
    chk("R1 init wins ec", 64'(ec_q), 64'd8);
    chk("R1 init wins rrb", 64'(rrb_q), 64'd8);

    // R7/R8/R9 back-to-back drain sequence with while-exit
    load(64'd0, 6'd2, 7'd1, 1'b1);
    req_valid = 1'b1; req_op = 2'd3; req_slot = 2'd2; req_qp = 1'b0;
    @(negedge clk);
    chk("R7 seq1 taken", 64'(rsp_taken), 64'd0);
    chk("R7 seq1 ec", 64'(ec_q), 64'd1);
    chk("R7 seq1 rrb", 64'(rrb_q), 64'd0);
    @(negedge clk);
    chk("R8 seq2 taken", 64'(rsp_taken), 64'd1);
    chk("R8 seq2 ec", 64'(ec_q), 64'd0);
    chk("R10 seq2 rrb", 64'(rrb_q), 64'd95);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 seq3 taken", 64'(rsp_taken), 64'd1);
    chk("R9 seq3 rrb", 64'(rrb_q), 64'd95);
    @(negedge clk);
    chk("R12 drop valid", 64'(rsp_valid), 64'd0);

    // R5 counted branch repeated until zero, then holds
    load(64'd2, 6'd0, 7'd0, 1'b0);
    req_valid = 1'b1; req_op = 2'd1; req_slot = 2'd2;
    @(negedge clk);
    @(negedge clk);
    chk("R4 count 2->0 taken", 64'(rsp_taken), 64'd1);
    chk("R4 count 2->0 lc", lc_q, 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 count hold taken", 64'(rsp_taken), 64'd0);
    chk("R5 count hold lc", lc_q, 64'd0);
    chk("R11 count hold we", 64'(lc_we), 64'd1);

    // R3 slot 3 with none opcode
    req_valid = 1'b1; req_op = 2'd0; req_slot = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 none fault", 64'(rsp_fault), 64'd0);
    chk("R3 none we", 64'({lc_we, ec_we, rrb_we, p63_we}), 64'd0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule